// File: doc/BRIEF.md
# Memory Read-Modify-Write Unit

This block takes one command at a time and turns it into a fused load, arithmetic or logic step, and store on a single byte, halfword or word of memory. A command carries a base byte address, an unsigned 6-bit offset that is scaled by the access size, a size code, an operation code, a 32-bit register operand and a 5-bit immediate. The unit reads the addressed word through a simple synchronous memory port with a fixed one-cycle read latency. It extracts the addressed field, sign-extends it to 32 bits, applies the operation, and writes the truncated result back to the same address. The write uses byte enables, so neighbouring bytes are left untouched.

Commands arrive on a valid/ready interface. The unit raises `cmd_ready` only while idle, so a command is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high. The payload must be stable in that cycle only. A command that is offered while the unit is busy is neither taken nor remembered, and the sender keeps it until `cmd_ready` returns. `busy` stays high from the accepting edge until the one-cycle `done` pulse ends. A misaligned or reserved-size command sets `rmw_err` together with `done` and does not touch memory.

Top module: `rmw_unit`

## Requirements
- R1: After reset the unit is idle: `cmd_ready` is 1, `busy`, `done`, `rmw_err`, `mem_rd_en` and `mem_wr_en` are 0.
- R2: The access address is `cmd_base + (cmd_off << cmd_size)` modulo 2^AW. The size codes are 0 = byte, 1 = halfword, 2 = word and 3 = reserved. Memory selects the word with address bits [AW-1:2].
- R3: The addressed field is taken from the read word at byte lane `addr[1:0]` and sign-extended to 32 bits. Register-operand operation codes are 0 = add, 1 = subtract (field minus operand), 2 = AND and 3 = OR.
- R4: Immediate operation codes are 4 = add the unsigned immediate, 5 = subtract the unsigned immediate, 6 = clear bit number imm, and 7 = set bit number imm.
- R5: The result is truncated to the access size and written to the same word and lane. Byte enables cover exactly that field: one lane for a byte, lanes {addr[1],0} and {addr[1],1} for a halfword, all four for a word. All other bytes keep their value.
- R6: Memory reads have a fixed one-cycle latency, and an aligned command follows a fixed schedule. Take the accepting edge as cycle 0. `mem_rd_en` is high in cycle 0 and `mem_wr_en` in cycle 3. `done` is high in cycle 4. Exactly one read and one write are made.
- R7: A halfword with addr[0]=1, a word with addr[1:0]≠0, or size code 3 makes no read and no write. `done` and `rmw_err` are then both high in the cycle after the accepting edge.
- R8: `cmd_ready` is low from the accepting edge until `done` has been pulsed. A command offered in that window is ignored and leaves memory unchanged.
- R9: `done` lasts exactly one cycle, and `rmw_err` is high only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, command taken on valid and ready |
| cmd_base | input | AW | Base byte address |
| cmd_off | input | OW | Unsigned offset, scaled by size |
| cmd_size | input | 2 | Access size code |
| cmd_op | input | 3 | Operation code |
| cmd_rval | input | 32 | Register operand |
| cmd_imm | input | IW | Immediate value or bit index |
| mem_rd_en | output | 1 | Read strobe |
| mem_wr_en | output | 1 | Write strobe |
| mem_addr | output | AW | Byte address of the access |
| mem_be | output | 4 | Write byte enables |
| mem_wdata | output | 32 | Lane-aligned write data |
| mem_rdata | input | 32 | Read data, valid one cycle after the read strobe |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rmw_err | output | 1 | Command skipped as misaligned or reserved size |

## Verification
Two events can coincide at the command port. A new command can be offered in the same cycle that `done` pulses, and one can be offered while a command is still running. To provoke this, the bench keeps `cmd_valid` high for the whole run of some commands. The held payload has a different operation, a different operand and a target word of its own. It drops only at the `done` cycle. The bench judges the outcome from the port: `cmd_ready` must stay low, the strobe counts must stay at one read and one write, and the held command's target word must be unchanged in a full memory comparison.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  localparam int DW = 32;
  localparam int NB = DW / 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

  typedef enum logic [2:0] {
    OP_ADD_R = 3'd0,
    OP_SUB_R = 3'd1,
    OP_AND_R = 3'd2,
    OP_OR_R  = 3'd3,
    OP_ADD_I = 3'd4,
    OP_SUB_I = 3'd5,
    OP_CLR_I = 3'd6,
    OP_SET_I = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_WAIT   = 3'd2,
    ST_MODIFY = 3'd3,
    ST_WRITE  = 3'd4,
    ST_DONE   = 3'd5
  } state_e;
endpackage

// File: rtl/rmw_agen.sv
module rmw_agen
  import rmw_pkg::*;
#(
  parameter int AW = 8,
  parameter int OW = 6
) (
  input  logic [AW-1:0] base,
  input  logic [OW-1:0] off,
  input  logic [1:0]    size,
  output logic [AW-1:0] addr,
  output logic          misalign,
  output logic [NB-1:0] be
);
  assign addr = base + (AW'(off) << size);

  always_comb begin
    case (size_e'(size))
      SZ_BYTE: misalign = 1'b0;
      SZ_HALF: misalign = addr[0];
      SZ_WORD: misalign = (addr[1:0] != 2'b00);
      default: misalign = 1'b1;
    endcase
  end

  for (genvar i = 0; i < NB; i++) begin : g_lane
    localparam logic [1:0] LANE = i[1:0];
    always_comb begin
      case (size_e'(size))
        SZ_BYTE: be[i] = (addr[1:0] == LANE);
        SZ_HALF: be[i] = (addr[1] == LANE[1]);
        SZ_WORD: be[i] = 1'b1;
        default: be[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/rmw_alu.sv
module rmw_alu
  import rmw_pkg::*;
#(
  parameter int IW = 5
) (
  input  logic [DW-1:0] rdata,
  input  logic [1:0]    lane,
  input  logic [1:0]    size,
  input  logic [2:0]    op,
  input  logic [DW-1:0] rval,
  input  logic [IW-1:0] imm,
  output logic [DW-1:0] wdata
);
  logic [DW-1:0] shifted, ext, operand, bitmask, result;

  assign shifted = rdata >> {lane, 3'b000};
  assign operand = op[2] ? DW'(imm) : rval;
  assign bitmask = DW'(1) << imm;

  always_comb begin
    case (size_e'(size))
      SZ_BYTE: ext = {{(DW-8){shifted[7]}}, shifted[7:0]};
      SZ_HALF: ext = {{(DW-16){shifted[15]}}, shifted[15:0]};
      default: ext = shifted;
    endcase
  end

  always_comb begin
    case (op_e'(op))
      OP_ADD_R, OP_ADD_I: result = ext + operand;
      OP_SUB_R, OP_SUB_I: result = ext - operand;
      OP_AND_R:           result = ext & operand;
      OP_OR_R:            result = ext | operand;
      OP_CLR_I:           result = ext & ~bitmask;
      default:            result = ext | bitmask;
    endcase
  end

  assign wdata = result << {lane, 3'b000};
endmodule

// File: rtl/rmw_fsm.sv
module rmw_fsm
  import rmw_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   accept,
  input  logic   skip,
  output state_e state
);
  state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:   if (accept) nxt = skip ? ST_DONE : ST_READ;
      ST_READ:   nxt = ST_WAIT;
      ST_WAIT:   nxt = ST_MODIFY;
      ST_MODIFY: nxt = ST_WRITE;
      ST_WRITE:  nxt = ST_DONE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/rmw_unit.sv
module rmw_unit
  import rmw_pkg::*;
#(
  parameter int AW = 8,
  parameter int OW = 6,
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [AW-1:0] cmd_base,
  input  logic [OW-1:0] cmd_off,
  input  logic [1:0]    cmd_size,
  input  logic [2:0]    cmd_op,
  input  logic [31:0]   cmd_rval,
  input  logic [IW-1:0] cmd_imm,
  output logic          mem_rd_en,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          rmw_err
);
  state_e        state;
  logic          accept, a_mis;
  logic [AW-1:0] a_addr, r_addr;
  logic [NB-1:0] a_be, r_be;
  logic [1:0]    r_size;
  logic [2:0]    r_op;
  logic [DW-1:0] r_rval, r_load, r_wdata, alu_out;
  logic [IW-1:0] r_imm;
  logic          r_err;

  assign accept = cmd_valid && cmd_ready;

  rmw_agen #(.AW(AW), .OW(OW)) u_agen (
    .base(cmd_base), .off(cmd_off), .size(cmd_size),
    .addr(a_addr), .misalign(a_mis), .be(a_be)
  );

  rmw_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .accept(accept), .skip(a_mis), .state(state)
  );

  rmw_alu #(.IW(IW)) u_alu (
    .rdata(r_load), .lane(r_addr[1:0]), .size(r_size), .op(r_op),
    .rval(r_rval), .imm(r_imm), .wdata(alu_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_addr  <= '0;
      r_be    <= '0;
      r_size  <= '0;
      r_op    <= '0;
      r_rval  <= '0;
      r_imm   <= '0;
      r_err   <= 1'b0;
      r_load  <= '0;
      r_wdata <= '0;
    end else begin
      if (accept) begin
        r_addr <= a_addr;
        r_be   <= a_be;
        r_size <= cmd_size;
        r_op   <= cmd_op;
        r_rval <= cmd_rval;
        r_imm  <= cmd_imm;
        r_err  <= a_mis;
      end
      if (state == ST_WAIT)   r_load  <= mem_rdata;
      if (state == ST_MODIFY) r_wdata <= alu_out;
    end
  end

  assign cmd_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE);
  assign rmw_err   = done && r_err;
  assign mem_rd_en = (state == ST_READ);
  assign mem_wr_en = (state == ST_WRITE);
  assign mem_addr  = r_addr;
  assign mem_be    = mem_wr_en ? r_be : '0;
  assign mem_wdata = r_wdata;
endmodule

// File: rtl/rmw_chk.sv
module rmw_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          mem_rd_en,
  input logic          mem_wr_en,
  input logic [AW-1:0] mem_addr,
  input logic [3:0]    mem_be,
  input logic          done,
  input logic          rmw_err
);
  a_r1_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));

  a_r5_enable_width: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 || $countones(mem_be) == 4));

  a_r6_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> ##3 (mem_wr_en && $stable(mem_addr)));

  a_r6_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> (done && !rmw_err));

  a_r7_err_skips_access: assert property (@(posedge clk) disable iff (!rst_n)
    rmw_err |-> ($past(cmd_ready) && !$past(mem_wr_en)));

  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    rmw_err |-> done);
endmodule

bind rmw_unit rmw_chk #(.AW(AW)) i_rmw_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
  .mem_be(mem_be), .done(done), .rmw_err(rmw_err)
);

// File: tb/test_rmw_unit.sv
module test_rmw_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [7:0]  cmd_base = '0;
  logic [5:0]  cmd_off = '0;
  logic [1:0]  cmd_size = '0;
  logic [2:0]  cmd_op = '0;
  logic [31:0] cmd_rval = '0;
  logic [4:0]  cmd_imm = '0;
  logic        mem_rd_en, mem_wr_en;
  logic [7:0]  mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        busy, done, rmw_err;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int rd_total = 0, wr_total = 0, last_rd = -1, last_wr = -1;

  logic [31:0] mem [0:63];
  logic [31:0] expm [0:63];

  always #2 clk = ~clk;

  rmw_unit i_rmw_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_base(cmd_base), .cmd_off(cmd_off), .cmd_size(cmd_size), .cmd_op(cmd_op),
    .cmd_rval(cmd_rval), .cmd_imm(cmd_imm), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .rmw_err(rmw_err)
  );

  function automatic logic [31:0] init_word(input int i);
    return (32'h8143_F0A7 ^ (32'(i) * 32'h0B01_9D13)) + 32'(i * 977);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= init_word(i);
      mem_rdata <= '0;
    end else begin
      if (mem_rd_en) mem_rdata <= mem[mem_addr[7:2]];
      if (mem_wr_en)
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[7:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
    end
  end

  always @(negedge clk) begin
    if (mem_rd_en) begin rd_total++; last_rd = cyc; end
    if (mem_wr_en) begin wr_total++; last_wr = cyc; end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] w, input logic [1:0] lane,
      input logic [1:0] size, input logic [2:0] op, input logic [31:0] rv, input logic [4:0] imm);
    int sh = int'(lane) * 8;
    logic [31:0] f = w >> sh;
    logic [31:0] r, m;
    if (size == 2'd0) begin f = 32'($signed(f[7:0]));  m = 32'hFF;   end
    else if (size == 2'd1) begin f = 32'($signed(f[15:0])); m = 32'hFFFF; end
    else m = 32'hFFFF_FFFF;
    case (op)
      3'd0: r = f + rv;
      3'd1: r = f - rv;
      3'd2: r = f & rv;
      3'd3: r = f | rv;
      3'd4: r = f + 32'(imm);
      3'd5: r = f - 32'(imm);
      3'd6: r = f & ~(32'd1 << imm);
      default: r = f | (32'd1 << imm);
    endcase
    m = m << sh;
    return (w & ~m) | ((r << sh) & m);
  endfunction

  task automatic run_cmd(input logic [1:0] size, input logic [1:0] lane, input logic [2:0] op,
      input logic [5:0] widx, input logic [5:0] off, input logic [31:0] rv,
      input logic [4:0] imm, input bit hold);
    logic [7:0] target = {widx, lane};
    bit exp_err = (size == 2'd3) || (size == 2'd1 && lane[0]) || (size == 2'd2 && lane != 2'd0);
    int rd0, wr0, acc, done_cyc, guard, rdy_hi, mism;
    string tag = (op < 3'd4) ? "R3" : "R4";
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_size = size; cmd_op = op; cmd_rval = rv; cmd_imm = imm; cmd_off = off;
    cmd_base = target - (8'(off) << size);
    rd0 = rd_total; wr0 = wr_total;
    @(posedge clk);
    #1;
    acc = cyc;
    if (hold) begin
      cmd_base = {widx ^ 6'd32, 2'b00};
      cmd_off = 6'd0; cmd_size = 2'd2; cmd_op = ~op; cmd_rval = ~rv;
    end else cmd_valid = 1'b0;
    guard = 0; rdy_hi = 0;
    do begin
      @(negedge clk);
      if (cmd_ready) rdy_hi++;
      guard++;
    end while (!done && guard < 20);
    done_cyc = cyc;
    check(done, "R6 done seen", 32'(done), 32'd1);
    check(rmw_err == exp_err, "R7 err flag", 32'(rmw_err), 32'(exp_err));
    check(rdy_hi == 0, "R8 ready low while busy", 32'(rdy_hi), 32'd0);
    cmd_valid = 1'b0;
    if (exp_err) begin
      check(rd_total == rd0 && wr_total == wr0, "R7 no access", 32'(rd_total - rd0 + wr_total - wr0), 32'd0);
      check(done_cyc == acc, "R7 done timing", 32'(done_cyc - acc), 32'd0);
    end else begin
      check(rd_total == rd0 + 1 && wr_total == wr0 + 1, "R6 one read one write (R8 held cmd ignored)",
            32'(rd_total - rd0) << 8 | 32'(wr_total - wr0), 32'h101);
      check(last_rd == acc, "R6 read cycle", 32'(last_rd - acc), 32'd0);
      check(last_wr == acc + 3, "R6 write cycle", 32'(last_wr - acc), 32'd3);
      check(done_cyc == acc + 4, "R6 done cycle", 32'(done_cyc - acc), 32'd4);
      expm[widx] = model(expm[widx], lane, size, op, rv, imm);
    end
    mism = 0;
    for (int i = 0; i < 64; i++) if (mem[i] !== expm[i]) mism++;
    check(mem[widx] === expm[widx], {tag, " R2 R5 target word"}, mem[widx], expm[widx]);
    check(mism == 0, "R5 R8 rest of memory unchanged", 32'(mism), 32'd0);
    @(negedge clk);
    check(!done && !rmw_err && cmd_ready, "R9 done one cycle", {30'd0, done, rmw_err}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) expm[i] = init_word(i);
    repeat (3) @(posedge clk);
    #1;
    check(cmd_ready && !busy && !done && !rmw_err && !mem_rd_en && !mem_wr_en,
          "R1 reset state", {26'd0, cmd_ready, busy, done, rmw_err, mem_rd_en, mem_wr_en}, 32'h20);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready && !busy, "R1 idle after reset", {30'd0, cmd_ready, busy}, 32'd2);
    for (int sz = 0; sz < 4; sz++)
      for (int ln = 0; ln < 4; ln++)
        for (int op = 0; op < 8; op++)
          for (int k = 0; k < 2; k++)
            run_cmd(2'(sz), 2'(ln), 3'(op), 6'((sz * 13 + ln * 5 + op * 3 + k * 11) & 31),
                    6'((op * 9 + ln * 7 + k * 5 + sz) & 63),
                    k ? 32'h7FFF_FF85 : 32'h0000_80F3,
                    5'((op * 7 + ln * 3 + k * 13) & 31), (k == 1) && op[0]);
    run_cmd(2'd0, 2'd3, 3'd7, 6'd9, 6'd63, 32'd0, 5'd31, 1'b0);
    run_cmd(2'd2, 2'd0, 3'd1, 6'd10, 6'd63, 32'h8000_0000, 5'd0, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule